// File: doc/BRIEF.md
# UART Transmitter with Urgent-Byte Insertion

This block is the transmit half of a UART. Bytes written by the host to the holding register are queued in a transmit FIFO and serialised one frame at a time on `txd`. The bits are paced by a single-cycle `baud_tick` input. The line format is set by port inputs: data length, parity and stop-bit count. Each frame takes the format that is present when that frame starts.

The host can also push one byte past the queue. It writes the control register with bit 0 set, which arms the request. Its next write to the holding register then captures that byte as urgent. At the next character boundary the urgent byte is sent before any FIFO content, and the queued bytes resume afterwards in their original order. A frame already on the line is never cut short. A pending software flow-control character, requested by a pulse on `flow_send`, outranks the urgent byte at a boundary.

The control bit is visible as `urgent_bit`. It clears itself when the urgent frame starts, so the host must arm the request again for every urgent byte.

Top module: `uart_tx_urgent`

## Requirements
- R1: After reset `txd` is high, `tx_busy` is 0, `urgent_bit` is 0 and `fifo_level` is 0. `txd` is high whenever no frame is in progress.
- R2: A frame starts only on a cycle with `baud_tick` high, and each bit lasts one tick interval. The frame has these bits in order:
  - a low start bit;
  - 5 + `data_len` data bits (`data_len` 0..3), LSB first;
  - a parity bit when `parity_en` is 1, equal to the XOR of the data bits, inverted when `parity_odd` is 1;
  - one high stop bit, or two when `two_stop` is 1.
- R3: A write to address 0 (holding register) while the request is not armed appends the byte to a 16-entry FIFO. Such a write while the FIFO is full is dropped. FIFO bytes are sent in write order.
- R4: A write to address 1 with `wr_data[0]`=1, while `tx_en` is 1 and no urgent byte is held, sets `urgent_bit`. The next write to address 0 captures its byte as the urgent byte, and `fifo_level` does not change.
- R5: While armed, a write to address 1 with `wr_data[0]`=0, or any write to address 2 or 3, clears `urgent_bit`. The next write to address 0 then goes to the FIFO.
- R6: The urgent byte is sent at the first character boundary after capture. It goes ahead of all FIFO bytes, never interrupts a frame in progress, and the FIFO bytes follow afterwards in unchanged order.
- R7: `urgent_bit` stays 1 from arming until the urgent frame starts, and clears at that start.
- R8: A `flow_send` pulse while `sw_flow_en` is 1 makes `flow_char` pending. At a boundary the pending flow character goes first, then the urgent byte, then the FIFO head.
- R9: While `tx_en` is 0 no new frame starts and an arming write has no effect. A frame already in progress completes.
- R10: A `flow_send` pulse while `sw_flow_en` is 0 has no effect on `txd`.
- R11: The urgent byte is framed with the data length, parity and stop settings present when its frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Transmitter enable |
| data_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Append a parity bit |
| parity_odd | input | 1 | Odd parity when 1, even when 0 |
| two_stop | input | 1 | Two stop bits when 1 |
| sw_flow_en | input | 1 | Software flow control enable |
| flow_send | input | 1 | Pulse: queue `flow_char` as the pending flow character |
| flow_char | input | 8 | Flow-control character value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 holding, 1 control, 2-3 other registers |
| wr_data | input | 8 | Write data |
| txd | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | A frame is on the line |
| urgent_bit | output | 1 | Send-immediate control bit readback |
| fifo_level | output | 5 | Bytes queued in the FIFO |
| fifo_full | output | 1 | FIFO holds 16 bytes |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse and that at most one register write arrives per cycle. Under those inputs the FIFO level moves by at most one step per cycle, and `txd` can change only on the cycle after a tick. The stimulus produces ticks from a free-running divide-by-four counter and issues every write as a one-cycle strobe. Line-format inputs are changed only between frames, except in the R11 case, where they change on purpose while the urgent byte waits.

// File: rtl/uart_tx_urgent.sv
module uart_tx_urgent #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       baud_tick,
  input  logic                       tx_en,
  input  logic [1:0]                 data_len,
  input  logic                       parity_en,
  input  logic                       parity_odd,
  input  logic                       two_stop,
  input  logic                       sw_flow_en,
  input  logic                       flow_send,
  input  logic [7:0]                 flow_char,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_addr,
  input  logic [7:0]                 wr_data,
  output logic                       txd,
  output logic                       tx_busy,
  output logic                       urgent_bit,
  output logic [$clog2(DEPTH):0]     fifo_level,
  output logic                       fifo_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int FW = 12;

  logic [7:0]    mem [DEPTH];
  logic [AW:0]   wp, rp;
  logic          armed, uvalid, fpend, busy;
  logic [7:0]    ubyte, fbyte, sel;
  logic [FW-1:0] sh, frame;
  logic [3:0]    cnt, nd, flen;
  logic          par;

  wire wr_thr     = wr_en && wr_addr == 2'd0;
  wire wr_ctl     = wr_en && wr_addr == 2'd1;
  wire wr_other   = wr_en && wr_addr[1];
  wire fifo_empty = wp == rp;
  wire boundary   = baud_tick && (!busy || cnt == 4'd1);
  wire start      = boundary && tx_en && (fpend || uvalid || !fifo_empty);
  wire take_flow  = start && fpend;
  wire take_urg   = start && !fpend && uvalid;
  wire take_fifo  = start && !fpend && !uvalid;
  wire push       = wr_thr && !armed && !fifo_full;

  assign fifo_level = wp - rp;
  assign fifo_full  = fifo_level == (AW+1)'(DEPTH);
  assign txd        = busy ? sh[0] : 1'b1;
  assign tx_busy    = busy;
  assign urgent_bit = armed | uvalid;
  assign sel        = fpend ? fbyte : (uvalid ? ubyte : mem[rp[AW-1:0]]);
  assign nd         = 4'd5 + {2'b00, data_len};
  assign flen       = nd + 4'd2 + {3'b000, parity_en} + {3'b000, two_stop};

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    par      = parity_odd;
    for (int i = 0; i < 8; i++)
      if (i < int'(nd)) begin
        frame[i+1] = sel[i];
        par        = par ^ sel[i];
      end
    if (parity_en) frame[nd+4'd1] = par;
  end

  always_ff @(posedge clk)
    if (push) mem[wp[AW-1:0]] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0;
      armed <= 1'b0; uvalid <= 1'b0; ubyte <= '0;
      fpend <= 1'b0; fbyte <= '0;
      busy <= 1'b0; sh <= '1; cnt <= '0;
    end else begin
      if (baud_tick && busy) begin
        sh  <= {1'b1, sh[FW-1:1]};
        cnt <= cnt - 4'd1;
      end
      if (boundary) begin
        busy <= start;
        if (start) begin
          sh  <= frame;
          cnt <= flen;
        end
      end
      if (take_fifo) rp <= rp + 1'b1;
      if (take_urg)  uvalid <= 1'b0;
      if (take_flow) fpend <= 1'b0;
      if (flow_send && sw_flow_en) begin
        fpend <= 1'b1;
        fbyte <= flow_char;
      end
      if (wr_thr && armed) begin
        ubyte  <= wr_data;
        uvalid <= 1'b1;
        armed  <= 1'b0;
      end
      if (push) wp <= wp + 1'b1;
      if (wr_ctl) begin
        if (!wr_data[0])           armed <= 1'b0;
        else if (tx_en && !uvalid) armed <= 1'b1;
      end
      if (wr_other) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_urgent_chk.sv
module uart_tx_urgent_chk #(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   baud_tick,
  input logic                   tx_en,
  input logic                   wr_en,
  input logic [1:0]             wr_addr,
  input logic [7:0]             wr_data,
  input logic                   txd,
  input logic                   tx_busy,
  input logic                   urgent_bit,
  input logic                   start,
  input logic [$clog2(DEPTH):0] fifo_level
);
  // R9
  busy_rise_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !$past(tx_busy)) |-> $past(tx_en && baud_tick));

  // R6
  txd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(baud_tick) |-> $stable(txd));

  // R7
  urgent_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(urgent_bit) |-> ($past(start) || $past(wr_en && wr_addr != 2'd0)));

  // R4
  urgent_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(urgent_bit) |-> $past(wr_en && wr_addr == 2'd1 && wr_data[0] && tx_en));

  // R3
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == $past(fifo_level)) || (fifo_level == $past(fifo_level) + 1'b1)
    || (fifo_level + 1'b1 == $past(fifo_level)));

  // R3
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_level) <= DEPTH);
endmodule

bind uart_tx_urgent uart_tx_urgent_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .txd(txd),
  .tx_busy(tx_busy), .urgent_bit(urgent_bit), .start(start),
  .fifo_level(fifo_level)
);

// File: tb/test_uart_tx_urgent.sv
module test_uart_tx_urgent;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, tx_en = 1'b0;
  logic [1:0] data_len = 2'd3;
  logic parity_en = 1'b0, parity_odd = 1'b0, two_stop = 1'b0;
  logic sw_flow_en = 1'b0, flow_send = 1'b0;
  logic [7:0] flow_char = 8'h00;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic txd, tx_busy, urgent_bit, fifo_full;
  logic [$clog2(DEPTH):0] fifo_level;

  uart_tx_urgent #(.DEPTH(DEPTH)) i_uart_tx_urgent (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, tc = 0;
  string cur_req = "R1";

  logic [7:0] q[$];
  bit fr[$];
  bit m_armed, m_uvalid, m_fpend, m_busy;
  logic [7:0] m_ubyte, m_fchar, m_b;
  bit full0, uv0, fp0, ar0, mp;

  task automatic check(input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got %0d expected %0d at cycle %0d", cur_req, what, got, exp, cyc);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    if (!rst_n) tc = 0;
    else tc = (tc + 1) % 4;
    baud_tick = rst_n && tc == 3;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got %0d expected below %0d", cyc, 100000);
      summary();
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); fr.delete();
      m_armed = 0; m_uvalid = 0; m_fpend = 0; m_busy = 0;
      m_ubyte = 0; m_fchar = 0;
    end else begin
      full0 = q.size() == DEPTH; uv0 = m_uvalid; fp0 = m_fpend; ar0 = m_armed;
      if (baud_tick) begin
        if (m_busy && fr.size() > 1) void'(fr.pop_front());
        else begin
          fr.delete(); m_busy = 0;
          if (tx_en && (fp0 || uv0 || q.size() > 0)) begin
            if (fp0) begin m_b = m_fchar; m_fpend = 0; end
            else if (uv0) begin m_b = m_ubyte; m_uvalid = 0; end
            else m_b = q.pop_front();
            fr.push_back(1'b0);
            mp = parity_odd;
            for (int i = 0; i < 5 + int'(data_len); i++) begin
              fr.push_back(m_b[i]);
              mp ^= m_b[i];
            end
            if (parity_en) fr.push_back(mp);
            fr.push_back(1'b1);
            if (two_stop) fr.push_back(1'b1);
            m_busy = 1;
          end
        end
      end
      if (flow_send && sw_flow_en) begin m_fpend = 1; m_fchar = flow_char; end
      if (wr_en) begin
        if (wr_addr == 2'd0) begin
          if (ar0) begin m_ubyte = wr_data; m_uvalid = 1; m_armed = 0; end
          else if (!full0) q.push_back(wr_data);
        end else if (wr_addr == 2'd1) begin
          if (!wr_data[0]) m_armed = 0;
          else if (tx_en && !uv0) m_armed = 1;
        end else m_armed = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("txd", int'(txd), m_busy ? int'(fr[0]) : 1);
      check("tx_busy", int'(tx_busy), int'(m_busy));
      check("urgent_bit", int'(urgent_bit), int'(m_armed | m_uvalid));
      check("fifo_level", int'(fifo_level), q.size());
      check("fifo_full", int'(fifo_full), int'(q.size() == DEPTH));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic flow(input logic [7:0] c);
    @(negedge clk); flow_send = 1'b1; flow_char = c;
    @(negedge clk); flow_send = 1'b0;
  endtask

  task automatic drain;
    while (m_busy || q.size() > 0 || m_uvalid || m_fpend) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic fmt(input logic [1:0] l, input logic pe, input logic po, input logic ts);
    data_len = l; parity_en = pe; parity_odd = po; two_stop = ts;
  endtask

  initial begin
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("reset txd", int'(txd), 1);
    check("reset level", int'(fifo_level), 0);

    cur_req = "R2";
    tx_en = 1'b1;
    fmt(2'd3, 1'b0, 1'b0, 1'b0);
    wr(2'd0, 8'h55); wr(2'd0, 8'hC3); wr(2'd0, 8'h01);
    drain();
    fmt(2'd0, 1'b1, 1'b0, 1'b1);
    wr(2'd0, 8'h1B); wr(2'd0, 8'h0E);
    drain();
    fmt(2'd2, 1'b1, 1'b1, 1'b0);
    wr(2'd0, 8'h7F); wr(2'd0, 8'h2A);
    drain();

    cur_req = "R3";
    fmt(2'd3, 1'b1, 1'b0, 1'b0);
    tx_en = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++) wr(2'd0, 8'(8'h40 + i));
    check("R3 full level", int'(fifo_level), DEPTH);
    tx_en = 1'b1;
    drain();

    cur_req = "R6";
    for (int i = 0; i < 5; i++) wr(2'd0, 8'(8'h90 + i));
    repeat (6) @(negedge clk);
    cur_req = "R4";
    wr(2'd1, 8'h01);
    check("R4 armed", int'(urgent_bit), 1);
    wr(2'd0, 8'hA5);
    cur_req = "R7";
    check("R7 held", int'(urgent_bit), 1);
    cur_req = "R6";
    drain();

    cur_req = "R5";
    wr(2'd1, 8'h01); wr(2'd2, 8'h00);
    check("R5 disarm other", int'(urgent_bit), 0);
    wr(2'd0, 8'h3C);
    wr(2'd1, 8'h01); wr(2'd1, 8'h00);
    check("R5 disarm ctl", int'(urgent_bit), 0);
    wr(2'd0, 8'hC5);
    drain();

    cur_req = "R8";
    sw_flow_en = 1'b1;
    for (int i = 0; i < 3; i++) wr(2'd0, 8'(8'hE0 + i));
    repeat (4) @(negedge clk);
    wr(2'd1, 8'h01); wr(2'd0, 8'h5A);
    flow(8'h13);
    drain();
    flow(8'h11);
    drain();

    cur_req = "R10";
    sw_flow_en = 1'b0;
    flow(8'h13);
    repeat (20) @(negedge clk);
    check("R10 idle txd", int'(txd), 1);

    cur_req = "R9";
    wr(2'd0, 8'h81); wr(2'd0, 8'h82);
    repeat (3) @(negedge clk);
    tx_en = 1'b0;
    wr(2'd1, 8'h01);
    check("R9 arm ignored", int'(urgent_bit), 0);
    repeat (120) @(negedge clk);
    tx_en = 1'b1;
    drain();

    cur_req = "R11";
    fmt(2'd3, 1'b0, 1'b0, 1'b0);
    wr(2'd0, 8'hF0);
    repeat (3) @(negedge clk);
    wr(2'd1, 8'h01); wr(2'd0, 8'hB6);
    fmt(2'd1, 1'b1, 1'b1, 1'b1);
    drain();

    summary();
  end
endmodule